// File: doc/BRIEF.md
# Indirectly Addressed GPIO Port

This block is an eight-pin general-purpose I/O port controlled from a small synchronous host bus. The host does not address the port's two control registers directly. It first loads a 4-bit selector into a pointer register. It then reads or writes a single shared window address, and the selector decides whether the access reaches the direction register or the pin data register.

Each pin has its own direction bit. The direction register drives an active-low output enable, so a 0 bit makes the pin an output and a 1 bit makes it an input. A write to the data register loads the output latch that feeds the pins. A read of the data register returns the pin levels after a two-flop synchronizer, and never the latch contents. Read data is registered and is valid in the cycle after the read strobe.

Top module: `gpio_win_port`

## Requirements
- R1: While reset is high and after it is released, `pin_oe_n` is 0xFF, `pin_out` is 0x00, the selector is 0 and `host_rdata` is 0x00, until a write changes them.
- R2: A write to host address 0xA stores `host_wdata[3:0]` as the selector. A read of 0xA returns the selector in bits 3:0 with bits 7:4 at 0.
- R3: A write to window address 0xE while the selector is 4'b1011 loads the direction register. From the next cycle `pin_oe_n` equals the written byte, with every bit independent. A read through the same selector returns the byte.
- R4: A write to 0xE while the selector is 4'b1010 loads the output latch. From the next cycle `pin_out` equals the written byte, whatever the direction bits are.
- R5: A read of 0xE while the selector is 4'b1010 returns the pin inputs after two synchronizer flops, not the output latch. A pin change made before clock edge k shows up in a read whose strobe is sampled at edge k+2, and not in reads sampled at edges k or k+1.
- R6: When the selector is any value other than 4'b1010 or 4'b1011, a write to 0xE leaves `pin_oe_n` and `pin_out` unchanged, and a read of 0xE returns 0x00.
- R7: Writes to any host address other than 0xA or 0xE change no state, and reads from such addresses return 0x00.
- R8: `host_rdata` carries the value selected by the read strobe sampled at the previous clock edge. It is 0x00 in every cycle that follows an edge where the read strobe was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 4 | Host register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Output latch driven toward the pins |
| pin_oe_n | output | 8 | Active-low per-pin output enable |

## Verification
The indirection is tried with selector values biased toward the two valid codes and mixed with random ones. This separates accesses that reach the direction register, accesses that reach the data register, and accesses to the window that are ignored. Random host addresses check that nothing outside the two decoded addresses touches state. Pin values are set to differ from the output latch, so a read that wrongly returned the latch would be caught. A directed test changes the pins and reads three times in a row to confirm the two-cycle synchronizer delay.

// File: rtl/gpio_win_pkg.sv
package gpio_win_pkg;

    localparam int PORT_W  = 8;
    localparam int HADDR_W = 4;
    localparam int SUB_W   = 4;

    localparam logic [HADDR_W-1:0] ADDR_SUBSEL = 4'hA;
    localparam logic [HADDR_W-1:0] ADDR_WINDOW = 4'hE;
    localparam logic [SUB_W-1:0]   SUB_DIR     = 4'b1011;
    localparam logic [SUB_W-1:0]   SUB_DATA    = 4'b1010;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_SUBSEL = 2'd1,
        TGT_DIR    = 2'd2,
        TGT_DATA   = 2'd3
    } target_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir_n;
        logic [PORT_W-1:0] latch;
    } port_state_t;

    function automatic target_e decode_target(
        input logic [HADDR_W-1:0] addr,
        input logic [SUB_W-1:0]   sub
    );
        target_e t;
        t = TGT_NONE;
        if (addr == ADDR_SUBSEL) begin
            t = TGT_SUBSEL;
        end else if (addr == ADDR_WINDOW) begin
            if (sub == SUB_DIR)
                t = TGT_DIR;
            else if (sub == SUB_DATA)
                t = TGT_DATA;
        end
        return t;
    endfunction

    function automatic logic [PORT_W-1:0] widen_sub(input logic [SUB_W-1:0] sub);
        return {{(PORT_W-SUB_W){1'b0}}, sub};
    endfunction

endpackage

// File: rtl/gpio_win_regs.sv
module gpio_win_regs
    import gpio_win_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [HADDR_W-1:0]  addr,
    input  logic [PORT_W-1:0]   wdata,
    output logic [SUB_W-1:0]    sub_q,
    output port_state_t         state_q
);

    target_e wr_tgt;
    assign wr_tgt = decode_target(addr, sub_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q         <= '0;
            state_q.dir_n <= '1;
            state_q.latch <= '0;
        end else if (wr) begin
            case (wr_tgt)
                TGT_SUBSEL: sub_q         <= wdata[SUB_W-1:0];
                TGT_DIR:    state_q.dir_n <= wdata;
                TGT_DATA:   state_q.latch <= wdata;
                default:    ;
            endcase
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_q.dir_n == '1 && state_q.latch == '0 && sub_q == '0));

    // R2
    subsel_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_SUBSEL) |=> sub_q == $past(wdata[SUB_W-1:0]));

    // R3
    dir_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_WINDOW && sub_q == SUB_DIR) |=> state_q.dir_n == $past(wdata));

    // R4
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_WINDOW && sub_q == SUB_DATA) |=> state_q.latch == $past(wdata));

    // R6
    window_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_WINDOW && sub_q != SUB_DIR && sub_q != SUB_DATA)
        |=> ($stable(state_q) && $stable(sub_q)));

    // R7
    addr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (addr != ADDR_WINDOW && addr != ADDR_SUBSEL) |=> ($stable(state_q) && $stable(sub_q)));

endmodule

// File: rtl/gpio_win_sync.sv
module gpio_win_sync
    import gpio_win_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pins_async,
    output logic [PORT_W-1:0] pins_sync
);

    logic [PORT_W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= pins_async;
    end

    // R5
    sync_head_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stage_q[0] == $past(pins_async));

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[k] <= '0;
            else     stage_q[k] <= stage_q[k-1];
        end

        // R5
        sync_shift_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> stage_q[k] == $past(stage_q[k-1]));
    end

    assign pins_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_win_rdmux.sv
module gpio_win_rdmux
    import gpio_win_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd,
    input  logic [HADDR_W-1:0] addr,
    input  logic [SUB_W-1:0]   sub_q,
    input  port_state_t        state_q,
    input  logic [PORT_W-1:0]  pins_sync,
    output logic [PORT_W-1:0]  rdata
);

    target_e           rd_tgt;
    logic [PORT_W-1:0] rd_sel;

    assign rd_tgt = decode_target(addr, sub_q);

    always_comb begin
        case (rd_tgt)
            TGT_SUBSEL: rd_sel = widen_sub(sub_q);
            TGT_DIR:    rd_sel = state_q.dir_n;
            TGT_DATA:   rd_sel = pins_sync;
            default:    rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_sel;
        else         rdata <= '0;
    end

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> rdata == '0);

    // R2
    subsel_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == ADDR_SUBSEL) |=> rdata[PORT_W-1:SUB_W] == '0);

    // R5
    data_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == ADDR_WINDOW && sub_q == SUB_DATA) |=> rdata == $past(pins_sync));

    // R6
    window_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == ADDR_WINDOW && sub_q != SUB_DIR && sub_q != SUB_DATA) |=> rdata == '0);

endmodule

// File: rtl/gpio_win_port.sv
module gpio_win_port
    import gpio_win_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [PORT_W-1:0]  host_wdata,
    output logic [PORT_W-1:0]  host_rdata,
    input  logic [PORT_W-1:0]  pin_in,
    output logic [PORT_W-1:0]  pin_out,
    output logic [PORT_W-1:0]  pin_oe_n
);

    logic [SUB_W-1:0]  sub_q;
    port_state_t       state_q;
    logic [PORT_W-1:0] pins_sync;

    gpio_win_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (host_wr),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .sub_q   (sub_q),
        .state_q (state_q)
    );

    gpio_win_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pins_async (pin_in),
        .pins_sync  (pins_sync)
    );

    gpio_win_rdmux u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .rd        (host_rd),
        .addr      (host_addr),
        .sub_q     (sub_q),
        .state_q   (state_q),
        .pins_sync (pins_sync),
        .rdata     (host_rdata)
    );

    assign pin_out  = state_q.latch;
    assign pin_oe_n = state_q.dir_n;

    // R3
    oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> $stable(pin_oe_n) && $stable(pin_out));

endmodule

// File: tb/gpio_win_port_tb.sv
module gpio_win_port_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] host_addr;
    logic       host_wr;
    logic       host_rd;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic [7:0] pin_in;
    logic [7:0] pin_out;
    logic [7:0] pin_oe_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [3:0] m_sub;
    logic [7:0] m_dir;
    logic [7:0] m_lat;

    always #2 clk = ~clk;

    gpio_win_port dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe_n   (pin_oe_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [3:0] s,
                                            input logic [7:0] d, input logic [7:0] p);
        if (a == 4'hA) return {4'h0, s};
        if (a == 4'hE && s == 4'b1011) return d;
        if (a == 4'hE && s == 4'b1010) return p;
        return 8'h00;
    endfunction

    function automatic string tag_for(input logic [3:0] a, input logic [3:0] s);
        if (a == 4'hA) return "R2";
        if (a == 4'hE && s == 4'b1011) return "R3";
        if (a == 4'hE && s == 4'b1010) return "R4";
        if (a == 4'hE) return "R6";
        return "R7";
    endfunction

    task automatic host_write(input logic [3:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
        if (a == 4'hA) m_sub = d[3:0];
        else if (a == 4'hE && m_sub == 4'b1011) m_dir = d;
        else if (a == 4'hE && m_sub == 4'b1010) m_lat = d;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        pin_in = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x01 expected 0x00");
            summary();
        end
    end

    initial begin
        logic [7:0] rv;
        void'($urandom(32'hC0FFEE));
        rst = 1'b1; host_addr = '0; host_wr = 1'b0; host_rd = 1'b0;
        host_wdata = '0; pin_in = 8'h00;
        m_sub = '0; m_dir = 8'hFF; m_lat = 8'h00;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 oe_n", pin_oe_n, 8'hFF);
        check("R1 out", pin_out, 8'h00);
        check("R1 rdata", host_rdata, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        host_read(4'hA, rv);
        check("R1 sub", rv, 8'h00);
        check("R1 oe_n after", pin_oe_n, 8'hFF);

        // R2 upper bits of the write data are dropped
        host_write(4'hA, 8'hF5);
        host_read(4'hA, rv);
        check("R2", rv, 8'h05);

        // R3 direction through selector 1011
        host_write(4'hA, 8'h0B);
        host_write(4'hE, 8'h3C);
        check("R3 oe_n", pin_oe_n, 8'h3C);
        host_read(4'hE, rv);
        check("R3 read", rv, 8'h3C);

        // R4 and R5 latch write; the read returns the pins, not the latch
        host_write(4'hA, 8'h0A);
        host_write(4'hE, 8'h5A);
        check("R4 out", pin_out, 8'h5A);
        check("R3 dir kept", pin_oe_n, 8'h3C);
        set_pins(8'hC3);
        host_read(4'hE, rv);
        check("R5 pins not latch", rv, 8'hC3);

        // R5 synchronizer delay: change before an edge, visible two edges later
        pin_in = 8'h81;
        host_read(4'hE, rv);
        check("R5 edge k", rv, 8'hC3);
        host_read(4'hE, rv);
        check("R5 edge k+1", rv, 8'hC3);
        host_read(4'hE, rv);
        check("R5 edge k+2", rv, 8'h81);

        // R6 invalid selector on the window
        host_write(4'hA, 8'h03);
        host_write(4'hE, 8'hA5);
        check("R6 oe_n", pin_oe_n, 8'h3C);
        check("R6 out", pin_out, 8'h5A);
        host_read(4'hE, rv);
        check("R6 read", rv, 8'h00);

        // R7 undecoded address
        host_write(4'h2, 8'h77);
        host_read(4'h2, rv);
        check("R7 read", rv, 8'h00);
        check("R7 out", pin_out, 8'h5A);

        // R8 idle rdata
        @(negedge clk);
        check("R8 idle", host_rdata, 8'h00);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [3:0] a;
            logic [7:0] d;
            op = $urandom_range(0, 9);
            case ($urandom_range(0, 4))
                0, 1:    a = 4'hE;
                2, 3:    a = 4'hA;
                default: a = 4'($urandom_range(0, 15));
            endcase
            if (op < 2) begin
                d = ($urandom_range(0, 3) != 0) ? {4'($urandom), 3'b101, 1'($urandom)}
                                                 : 8'($urandom);
                host_write(4'hA, d);
            end else if (op < 5) begin
                string t;
                t = tag_for(a, m_sub);
                d = 8'($urandom);
                host_write(a, d);
                check({t, " oe_n"}, pin_oe_n, m_dir);
                check({t, " out"}, pin_out, m_lat);
            end else if (op < 8) begin
                string t;
                t = (a == 4'hE && m_sub == 4'b1010) ? "R5" : tag_for(a, m_sub);
                host_read(a, rv);
                check({t, " read"}, rv, exp_read(a, m_sub, m_dir, pin_in));
            end else if (op == 8) begin
                set_pins(8'($urandom));
            end else begin
                @(negedge clk);
                check("R8 idle", host_rdata, 8'h00);
            end
        end

        done = 1'b1;
        summary();
    end

endmodule